// File: doc/BRIEF.md
# Dual-Clock FIFO Fill Flag Generator

This block produces two active-low fill-level flags for a FIFO whose write side and read side run on unrelated clocks. The first flag, `paf_n`, warns that the FIFO is nearly full. The second, `hf_n`, reports that the FIFO holds more than half its depth. The block receives the binary write pointer in the write-clock domain and the binary read pointer in the read-clock domain. It Gray-codes each pointer and carries it across to the other domain through a multi-flop synchronizer. Each domain then works out its own view of the fill level as a modular pointer difference.

Two timing disciplines are available. In the compatible discipline, a flag can only become active because of write-side activity and can only clear because of read-side activity, so it is neither purely write-timed nor purely read-timed. In the enhanced discipline, configuration bits tie each flag to one clock: the almost-full flag can be tied to the write clock, and the half-full flag can be tied to either clock. The almost-full threshold comes from a programmable offset, which the block holds in a small register. When cascade operation is selected, the half-full output is held inactive because its pin carries expansion signalling in that configuration.

Top module: `ffg_status_flags`

## Requirements
- R1: While `rst` is high, and after it is released, both flags read 1 (inactive) for an empty FIFO. Reset reloads the almost-full offset with its default of 127, so with the default depth of 2048 the almost-full flag again falls at a fill of exactly 1921.
- R2: `paf_n` is 0 exactly when fill >= DEPTH - offset and 1 otherwise (default DEPTH = 2048).
- R3: `hf_n` is 0 exactly when fill > DEPTH/2; with DEPTH = 2048 it is 1 at a fill of 1024 and 0 at 1025.
- R4: Fill is `(wr_ptr - rd_ptr)` modulo 2*DEPTH, where both pointers are AW+1 = 12 bits wide and the top bit marks the wrap. The result is correct when the read pointer is numerically above the write pointer.
- R5: With `emode` = 0, each flag moves from 1 to 0 with the read clock stopped and the write clock running, and moves from 0 to 1 with the write clock stopped and the read clock running.
- R6: With `emode` = 1 and `ctl_paf_wsync` = 1, `paf_n` is updated only by write-clock edges: reads made while the write clock is stopped leave it at 0.
- R7: With `emode` = 1, `ctl_hf_wclk` = 1 ties `hf_n` to the write clock, and `ctl_hf_wclk` = 0 ties it to the read clock. A change of fill is not seen on `hf_n` while the selected clock is stopped, and it is seen once that clock runs again.
- R8: A write-clock edge with `ofs_ld` = 1 loads `ofs_val` (0 to DEPTH) as the offset. The offset values 500 and 0 give thresholds of 1548 and 2048.
- R9: When `cascade` = 1, `hf_n` reads 1 whatever the fill, and `paf_n` is unaffected.
- R10: With `emode` = 1 and `ctl_paf_wsync` = 0, `paf_n` follows the compatible discipline of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_ptr | input | 12 | Binary write pointer with wrap bit, write domain |
| rd_ptr | input | 12 | Binary read pointer with wrap bit, read domain |
| ofs_ld | input | 1 | Load strobe for the almost-full offset, write domain |
| ofs_val | input | 12 | Offset value to load (0 to DEPTH) |
| emode | input | 1 | 0 = compatible timing, 1 = enhanced timing |
| ctl_paf_wsync | input | 1 | Enhanced mode: 1 ties `paf_n` to the write clock |
| ctl_hf_wclk | input | 1 | Enhanced mode: 1 ties `hf_n` to the write clock, 0 to the read clock |
| cascade | input | 1 | 1 forces `hf_n` inactive |
| paf_n | output | 1 | Almost-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
A pointer change reaches a flag timed in its own domain two edges later: one edge registers the pointer and the next updates the flag. Across domains it takes one source edge plus two synchronizer edges plus one flag edge. In compatible mode, a clear also waits for the earlier set to cross over, which adds roughly four more edges. Each stimulus is therefore followed by a 30-cycle quiet window before the scoreboard compares both flags, and samples are taken at times that lie away from either clock's edges. The stopped-clock checks freeze one clock during that window, which shows which edge is allowed to move each flag.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

    // Timing discipline of one flag
    typedef enum logic [1:0] {
        TM_ASYM  = 2'd0,   // set by write side, cleared by read side
        TM_WSYNC = 2'd1,   // registered on the write clock only
        TM_RSYNC = 2'd2    // registered on the read clock only
    } tmode_e;

    localparam int GW_MAX = 16;   // widest pointer the Gray helpers cover

    function automatic logic [GW_MAX-1:0] bin2gray(input logic [GW_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW_MAX-1:0] gray2bin(input logic [GW_MAX-1:0] g);
        logic [GW_MAX-1:0] b;
        b[GW_MAX-1] = g[GW_MAX-1];
        for (int i = GW_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic tmode_e paf_mode(input logic emode, input logic wsync);
        return (emode && wsync) ? TM_WSYNC : TM_ASYM;
    endfunction

    function automatic tmode_e hf_mode(input logic emode, input logic on_wclk);
        if (!emode) return TM_ASYM;
        return on_wclk ? TM_WSYNC : TM_RSYNC;
    endfunction

endpackage

// File: rtl/ffg_ptr_sync.sv
module ffg_ptr_sync
    import ffg_pkg::*;
#(
    parameter int PW     = 12,
    parameter int STAGES = 2
) (
    input  logic          src_clk,
    input  logic          src_rst,
    input  logic [PW-1:0] src_bin,
    output logic [PW-1:0] src_q,
    input  logic          dst_clk,
    input  logic          dst_rst,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0] gray_q;
    logic [PW-1:0] chain [STAGES];

    // Source side: registered binary copy and its Gray code, same edge
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            src_q  <= '0;
            gray_q <= '0;
        end else begin
            src_q  <= src_bin;
            gray_q <= PW'(bin2gray(GW_MAX'(src_bin)));
        end
    end

    // Destination side synchronizer chain
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge dst_clk) begin
                if (dst_rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= gray_q;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dst_bin = PW'(gray2bin(GW_MAX'(chain[STAGES-1])));

endmodule

// File: rtl/ffg_flag_core.sv
module ffg_flag_core
    import ffg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   wclk,
    input  logic   wrst,
    input  logic   rclk,
    input  logic   rrst,
    input  tmode_e mode,
    input  logic   hit_w,    // threshold met, write-domain view
    input  logic   hit_r,    // threshold met, read-domain view
    output logic   flag_n
);

    logic              set_t, w_reg;
    logic              clr_t, r_reg;
    logic [STAGES-1:0] clr_s;   // clear toggle seen by write side
    logic [STAGES-1:0] set_s;   // set toggle seen by read side
    logic              asserted;

    // Write domain: raise the flag (toggle) only when it looks inactive
    always_ff @(posedge wclk) begin
        if (wrst) begin
            set_t <= 1'b0;
            w_reg <= 1'b0;
            clr_s <= '0;
        end else begin
            clr_s <= {clr_s[STAGES-2:0], clr_t};
            w_reg <= hit_w;
            if ((set_t == clr_s[STAGES-1]) && hit_w) begin
                set_t <= ~set_t;
            end
        end
    end

    // Read domain: drop the flag only once the set has arrived here
    always_ff @(posedge rclk) begin
        if (rrst) begin
            clr_t <= 1'b0;
            r_reg <= 1'b0;
            set_s <= '0;
        end else begin
            set_s <= {set_s[STAGES-2:0], set_t};
            r_reg <= hit_r;
            if ((set_s[STAGES-1] != clr_t) && !hit_r) begin
                clr_t <= ~clr_t;
            end
        end
    end

    always_comb begin
        case (mode)
            TM_WSYNC: asserted = w_reg;
            TM_RSYNC: asserted = r_reg;
            default:  asserted = set_t ^ clr_t;
        endcase
    end

    assign flag_n = ~asserted;

    // R5: the write side raises the flag only after seeing the threshold met
    a_r5_set_needs_hit: assert property (@(posedge wclk) disable iff (wrst)
        !$stable(set_t) |-> $past(hit_w));

    // R5: the read side clears the flag only after seeing the threshold missed
    a_r5_clr_needs_miss: assert property (@(posedge rclk) disable iff (rrst)
        !$stable(clr_t) |-> !$past(hit_r));

    // R5: no second set before the clear has come back
    a_r5_single_set: assert property (@(posedge wclk) disable iff (wrst)
        !$stable(set_t) |=> $stable(set_t));

    // R5: no second clear before a new set has arrived
    a_r5_single_clr: assert property (@(posedge rclk) disable iff (rrst)
        !$stable(clr_t) |=> $stable(clr_t));

endmodule

// File: rtl/ffg_status_flags.sv
module ffg_status_flags
    import ffg_pkg::*;
#(
    parameter int AW      = 11,
    parameter int DEF_OFS = 127,
    parameter int STAGES  = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic [AW:0]   wr_ptr,
    input  logic [AW:0]   rd_ptr,
    input  logic          ofs_ld,
    input  logic [AW:0]   ofs_val,
    input  logic          emode,
    input  logic          ctl_paf_wsync,
    input  logic          ctl_hf_wclk,
    input  logic          cascade,
    output logic          paf_n,
    output logic          hf_n
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;
    localparam int NFLAG = 2;          // index 0: almost full, 1: half full

    logic [PW-1:0] ofs_q;
    logic [PW-1:0] wq, rq, w_in_r, r_in_w;
    logic [PW-1:0] fill_w, fill_r, paf_thr;
    logic [NFLAG-1:0] hit_w, hit_r, flg_n;
    tmode_e           mode_sel [NFLAG];

    // Almost-full offset, write domain
    always_ff @(posedge wclk) begin
        if (rst)         ofs_q <= PW'(DEF_OFS);
        else if (ofs_ld) ofs_q <= ofs_val;
    end

    ffg_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_wptr (
        .src_clk(wclk), .src_rst(rst), .src_bin(wr_ptr), .src_q(wq),
        .dst_clk(rclk), .dst_rst(rst), .dst_bin(w_in_r)
    );

    ffg_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_rptr (
        .src_clk(rclk), .src_rst(rst), .src_bin(rd_ptr), .src_q(rq),
        .dst_clk(wclk), .dst_rst(rst), .dst_bin(r_in_w)
    );

    // Modular fill seen from each side
    assign fill_w  = wq - r_in_w;
    assign fill_r  = w_in_r - rq;
    assign paf_thr = PW'(DEPTH) - ofs_q;

    assign hit_w[0] = (fill_w >= paf_thr);
    assign hit_r[0] = (fill_r >= paf_thr);
    assign hit_w[1] = (fill_w > PW'(HALF));
    assign hit_r[1] = (fill_r > PW'(HALF));

    assign mode_sel[0] = paf_mode(emode, ctl_paf_wsync);
    assign mode_sel[1] = hf_mode(emode, ctl_hf_wclk);

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            ffg_flag_core #(.STAGES(STAGES)) u_core (
                .wclk(wclk), .wrst(rst), .rclk(rclk), .rrst(rst),
                .mode(mode_sel[g]), .hit_w(hit_w[g]), .hit_r(hit_r[g]),
                .flag_n(flg_n[g])
            );
        end
    endgenerate

    assign paf_n = flg_n[0];
    assign hf_n  = cascade | flg_n[1];

    // R8: a loaded offset never exceeds the depth
    a_r8_offset_in_range: assert property (@(posedge wclk) disable iff (rst)
        ofs_q <= PW'(DEPTH));

endmodule

// File: tb/ffg_status_flags_test.sv
module ffg_status_flags_test;

    localparam int AW    = 11;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wclk_en = 1'b1, rclk_en = 1'b1;
    logic          rst = 1'b1;
    logic [PW-1:0] wr_ptr = '0, rd_ptr = '0, ofs_val = '0;
    logic          ofs_ld = 1'b0;
    logic          emode = 1'b0, ctl_paf_wsync = 1'b0, ctl_hf_wclk = 1'b0, cascade = 1'b0;
    logic          paf_n, hf_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        bit    paf;
        bit    hf;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;

    ffg_status_flags #(.AW(AW)) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .ofs_ld(ofs_ld), .ofs_val(ofs_val),
        .emode(emode), .ctl_paf_wsync(ctl_paf_wsync), .ctl_hf_wclk(ctl_hf_wclk),
        .cascade(cascade), .paf_n(paf_n), .hf_n(hf_n)
    );

    // 100 MHz clocks; read clock offset by 3 ns; each can be frozen low
    initial forever #5 wclk = wclk_en ? ~wclk : 1'b0;
    initial begin
        #3;
        forever #5 rclk = rclk_en ? ~rclk : 1'b0;
    end

    // Driver side: push expected values, then wake the monitor
    task automatic expect_flags(input bit e_paf, input bit e_hf, input string tag);
        exp_t e;
        e.paf = e_paf;
        e.hf  = e_hf;
        e.tag = tag;
        sb_q.push_back(e);
        ->mon_ev;
        #5;
    endtask

    task automatic settle();
        #300;
    endtask

    // Monitor: compares the design outputs against queued expectations
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (paf_n !== e.paf || hf_n !== e.hf) begin
                    errors++;
                    $display("FAIL %s: actual paf_n=%b hf_n=%b expected paf_n=%b hf_n=%b",
                             e.tag, paf_n, hf_n, e.paf, e.hf);
                end
            end
        end
    end

    task automatic set_ptrs(input int w, input int r);
        wr_ptr = PW'(w % (2 * DEPTH));
        rd_ptr = PW'(r % (2 * DEPTH));
        settle();
    endtask

    initial begin
        #1;
        rst = 1'b1;
        #100;
        rst = 1'b0;
        #50;
        expect_flags(1, 1, "R1 reset state");

        // R3 / R2 thresholds with default offset 127
        set_ptrs(1024, 0);  expect_flags(1, 1, "R3 fill 1024");
        set_ptrs(1025, 0);  expect_flags(1, 0, "R3 fill 1025");
        set_ptrs(1920, 0);  expect_flags(1, 0, "R2 fill 1920");
        set_ptrs(1921, 0);  expect_flags(0, 0, "R2 fill 1921");
        set_ptrs(1921, 1);  expect_flags(1, 0, "R2 read drops fill to 1920");

        // R4 modular fill with read pointer above write pointer
        set_ptrs(1404, 4000); expect_flags(1, 0, "R4 wrapped fill 1500");
        set_ptrs(300, 4000);  expect_flags(1, 1, "R4 wrapped fill 396");
        set_ptrs(3969, 1952); expect_flags(0, 0, "R4 fill 2017");

        // R5 compatible: fall with read clock frozen, rise with write clock frozen
        set_ptrs(0, 0);       expect_flags(1, 1, "R5 empty");
        rclk_en = 1'b0; #50;
        wr_ptr = PW'(1930); settle();
        expect_flags(0, 0, "R5 fall on write clock alone");
        wclk_en = 1'b0; rclk_en = 1'b1; #50;
        rd_ptr = PW'(1000); settle();
        expect_flags(1, 1, "R5 rise on read clock alone");
        wclk_en = 1'b1; settle();
        expect_flags(1, 1, "R5 both clocks running");

        // R6 / R7 enhanced, both flags on write clock
        emode = 1'b1; ctl_paf_wsync = 1'b1; ctl_hf_wclk = 1'b1;
        set_ptrs(1000, 1000); expect_flags(1, 1, "R6 enhanced empty");
        set_ptrs(2930, 1000); expect_flags(0, 0, "R6 enhanced fill 1930");
        wclk_en = 1'b0; #50;
        rd_ptr = PW'(2000); settle();
        expect_flags(0, 0, "R6 R7 write-timed flags hold without write clock");
        wclk_en = 1'b1; settle();
        expect_flags(1, 1, "R6 R7 update after write clock resumes");

        // R7 half-full on read clock
        ctl_hf_wclk = 1'b0; settle();
        rclk_en = 1'b0; #50;
        wr_ptr = PW'(3500); settle();
        expect_flags(1, 1, "R7 read-timed hf holds without read clock");
        rclk_en = 1'b1; settle();
        expect_flags(1, 0, "R7 read-timed hf after read clock resumes");

        // R10 enhanced with wsync clear behaves as compatible
        ctl_paf_wsync = 1'b0; settle();
        rclk_en = 1'b0; #50;
        wr_ptr = PW'(3950); settle();
        expect_flags(0, 0, "R10 paf falls on write clock alone");
        wclk_en = 1'b0; rclk_en = 1'b1; #50;
        rd_ptr = PW'(3000); settle();
        expect_flags(1, 1, "R10 paf rises on read clock alone");
        wclk_en = 1'b1; settle();

        // R8 offset loading
        emode = 1'b0;
        ofs_val = PW'(500); ofs_ld = 1'b1; #20; ofs_ld = 1'b0;
        set_ptrs(3000 + 1547, 3000); expect_flags(1, 0, "R8 offset 500 fill 1547");
        set_ptrs(3000 + 1548, 3000); expect_flags(0, 0, "R8 offset 500 fill 1548");
        ofs_val = PW'(0); ofs_ld = 1'b1; #20; ofs_ld = 1'b0;
        set_ptrs(3000 + 2047, 3000); expect_flags(1, 0, "R8 offset 0 fill 2047");
        set_ptrs(3000 + 2048, 3000); expect_flags(0, 0, "R8 offset 0 fill 2048");

        // R9 cascade hides half-full
        cascade = 1'b1; settle();
        expect_flags(0, 1, "R9 cascade forces hf_n high");
        cascade = 1'b0; settle();
        expect_flags(0, 0, "R9 cascade released");

        // R1 reset reloads the default offset
        set_ptrs(0, 0);
        rst = 1'b1; #100; rst = 1'b0; #100;
        expect_flags(1, 1, "R1 flags after second reset");
        set_ptrs(1920, 0); expect_flags(1, 0, "R1 default offset fill 1920");
        set_ptrs(1921, 0); expect_flags(0, 0, "R1 default offset fill 1921");

        #20;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule